// File: doc/BRIEF.md
# Transport Stream Packet Sync Lock

This block sits behind a byte-wide transport stream input and finds where the packets begin. It searches the incoming bytes for a sync token. It then checks that the same token keeps appearing at a fixed packet spacing. Once enough spaced tokens have been seen in a row, it declares lock and starts forwarding bytes downstream, with a start-of-packet flag on each packet's first byte. While locked it tolerates isolated missing tokens, and it gives up alignment only after a programmed run of misses at consecutive packet boundaries.

Four values are inputs: the token value, the packet length in bytes, the number of consecutive spaced tokens needed for lock, and the number of consecutive missing tokens that end lock. A typical setting is a token of 0x47, a length of 188, and a threshold of 9 for both counts. The block advances only on bytes qualified by a valid strobe. A synchronous reset or a low enable returns it to the search state.

Top module: `ts_sync_lock`

## Requirements
- R1: A high `rst`, or a low `en`, at a clock edge puts `sync_state` to hunt (2'd0) and clears both run counters and the packet position. `out_valid` and `out_sop` are low from that edge on.
- R2: In hunt, an accepted byte equal to `cfg_token` becomes packet position 0 and moves the block to verify (2'd1). It moves straight to locked when the lock threshold is 0 or 1. Any other byte leaves the block in hunt, and hunt never moves directly to lost (2'd3).
- R3: In verify, each token found at a packet boundary extends the run of matches. The run counts the token that started the candidate. When the run reaches `cfg_lock_cnt` (treated as 1 when 0), the state becomes locked (2'd2).
- R4: In verify, a byte at a packet boundary that is not the token returns the block to hunt. Verify never moves directly to lost.
- R5: In locked, a missing token at a boundary moves the block to lost (2'd3) and its packet is still forwarded. A token at a later boundary returns the block to locked and clears the miss run. Locked never returns to verify.
- R6: When `cfg_drop_cnt` consecutive boundaries lack the token (treated as 1 when 0), the block returns to hunt. The byte that completes the run is not forwarded.
- R7: One cycle after an accepted byte, `out_valid` is high exactly when the state after that byte is locked or lost. `out_data` then equals that byte unchanged, with bit 7 as the first bit in serial order. `out_sop` is high only with `out_valid`, and only for a byte at packet position 0.
- R8: A cycle with `in_valid` low changes neither the state nor the position, and gives `out_valid` low one cycle later.
- R9: Packet boundaries recur every `cfg_pkt_len` accepted bytes, counted from the byte that started the candidate. The length is programmable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enable; low holds the block in hunt |
| in_valid | input | 1 | Input byte qualifier |
| in_data | input | DATA_W | Input byte |
| cfg_token | input | DATA_W | Sync token value |
| cfg_pkt_len | input | LEN_W | Packet length in bytes |
| cfg_lock_cnt | input | CNT_W | Spaced tokens needed for lock |
| cfg_drop_cnt | input | CNT_W | Consecutive misses that end lock |
| out_valid | output | 1 | Forwarded byte valid |
| out_sop | output | 1 | Forwarded byte is the first of a packet |
| out_data | output | DATA_W | Forwarded byte |
| sync_state | output | 2 | 0 hunt, 1 verify, 2 locked, 3 lost |
| locked | output | 1 | High in locked or lost |

## Verification
Two decisions can fall on the same boundary byte. One is the loss of lock. The other is whether that byte is forwarded. The bench drives exactly the drop-count-th corrupted token, with thresholds of 9, 2 and 1. A reference model predicts that `out_valid` stays low for that byte, while the previous miss, which still left the block in lost, was forwarded with `out_sop` high. A second coincidence is a lock-completing token under a lock threshold of 1. In that case the first token ever seen is forwarded at once as a start of packet, and the model judges this on every clock.

// File: rtl/ts_sync_pkg.sv
package ts_sync_pkg;

   typedef enum logic [1:0] {
      ST_HUNT   = 2'd0,
      ST_VERIFY = 2'd1,
      ST_LOCKED = 2'd2,
      ST_LOST   = 2'd3
   } sync_st_e;

   function automatic logic st_forwards(input sync_st_e s);
      return (s == ST_LOCKED) || (s == ST_LOST);
   endfunction

endpackage

// File: rtl/ts_sync_pos.sv
// Packet position tracker: flags the byte that sits on a packet boundary.
module ts_sync_pos #(
   parameter int LEN_W    = 8,
   parameter bit DOWN_CNT = 1'b0
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             adv,
   input  logic [LEN_W-1:0] pkt_len,
   output logic             at_mark
);

   logic short_pkt;
   assign short_pkt = (pkt_len <= LEN_W'(1));

   generate
      if (DOWN_CNT) begin : g_down
         logic [LEN_W-1:0] rem_q;
         always_ff @(posedge clk) begin
            if (clr) begin
               rem_q <= '0;
            end else if (adv) begin
               if (rem_q == '0) begin
                  rem_q <= short_pkt ? '0 : (pkt_len - LEN_W'(1));
               end else begin
                  rem_q <= rem_q - LEN_W'(1);
               end
            end
         end
         assign at_mark = (rem_q == '0);
      end else begin : g_up
         logic [LEN_W-1:0] pos_q;
         logic             last;
         assign last = short_pkt || (pos_q >= (pkt_len - LEN_W'(1)));
         always_ff @(posedge clk) begin
            if (clr) begin
               pos_q <= '0;
            end else if (adv) begin
               pos_q <= last ? '0 : (pos_q + LEN_W'(1));
            end
         end
         assign at_mark = (pos_q == '0);
      end
   endgenerate

endmodule

// File: rtl/ts_sync_fsm.sv
// Alignment state machine with match and miss run counters.
module ts_sync_fsm
   import ts_sync_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             hold_clr,
   input  logic             acc,
   input  logic             is_tok,
   input  logic             at_mark,
   input  logic [CNT_W-1:0] lock_cnt,
   input  logic [CNT_W-1:0] drop_cnt,
   output sync_st_e         state_q,
   output logic             fwd,
   output logic             fwd_sop,
   output logic             pos_clr
);

   localparam int RUN_W = CNT_W + 1;

   sync_st_e         state_d;
   logic [RUN_W-1:0] mrun_q, mrun_d, xrun_q, xrun_d;
   logic [RUN_W-1:0] lock_lim, drop_lim, mrun_inc, xrun_inc;

   assign lock_lim = (lock_cnt == '0) ? RUN_W'(1) : {1'b0, lock_cnt};
   assign drop_lim = (drop_cnt == '0) ? RUN_W'(1) : {1'b0, drop_cnt};
   assign mrun_inc = mrun_q + RUN_W'(1);
   assign xrun_inc = xrun_q + RUN_W'(1);

   always_comb begin
      state_d = state_q;
      mrun_d  = mrun_q;
      xrun_d  = xrun_q;
      if (acc) begin
         unique case (state_q)
            ST_HUNT: begin
               if (is_tok) begin
                  xrun_d = '0;
                  if (lock_lim == RUN_W'(1)) begin
                     state_d = ST_LOCKED;
                     mrun_d  = '0;
                  end else begin
                     state_d = ST_VERIFY;
                     mrun_d  = RUN_W'(1);
                  end
               end
            end
            ST_VERIFY: begin
               if (at_mark) begin
                  if (!is_tok) begin
                     state_d = ST_HUNT;
                     mrun_d  = '0;
                  end else if (mrun_inc >= lock_lim) begin
                     state_d = ST_LOCKED;
                     mrun_d  = '0;
                  end else begin
                     mrun_d = mrun_inc;
                  end
               end
            end
            ST_LOCKED: begin
               if (at_mark && !is_tok) begin
                  if (drop_lim == RUN_W'(1)) begin
                     state_d = ST_HUNT;
                     xrun_d  = '0;
                  end else begin
                     state_d = ST_LOST;
                     xrun_d  = RUN_W'(1);
                  end
               end
            end
            ST_LOST: begin
               if (at_mark) begin
                  if (is_tok) begin
                     state_d = ST_LOCKED;
                     xrun_d  = '0;
                  end else if (xrun_inc >= drop_lim) begin
                     state_d = ST_HUNT;
                     xrun_d  = '0;
                  end else begin
                     xrun_d = xrun_inc;
                  end
               end
            end
            default: state_d = ST_HUNT;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (hold_clr) begin
         state_q <= ST_HUNT;
         mrun_q  <= '0;
         xrun_q  <= '0;
      end else begin
         state_q <= state_d;
         mrun_q  <= mrun_d;
         xrun_q  <= xrun_d;
      end
   end

   assign fwd     = acc && st_forwards(state_d);
   assign fwd_sop = fwd && at_mark;
   assign pos_clr = hold_clr || (state_d == ST_HUNT);

endmodule

// File: rtl/ts_sync_out.sv
// Output register stage for forwarded bytes.
module ts_sync_out #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              hold_clr,
   input  logic              fwd,
   input  logic              fwd_sop,
   input  logic [DATA_W-1:0] byte_in,
   output logic              out_valid,
   output logic              out_sop,
   output logic [DATA_W-1:0] out_data
);

   always_ff @(posedge clk) begin
      if (hold_clr) begin
         out_valid <= 1'b0;
         out_sop   <= 1'b0;
      end else begin
         out_valid <= fwd;
         out_sop   <= fwd_sop;
      end
   end

   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
         always_ff @(posedge clk) begin
            if (hold_clr) begin
               out_data[b] <= 1'b0;
            end else if (fwd) begin
               out_data[b] <= byte_in[b];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/ts_sync_lock.sv
// Transport stream packet sync lock, top level.
module ts_sync_lock
   import ts_sync_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int LEN_W    = 8,
   parameter int CNT_W    = 4,
   parameter bit DOWN_CNT = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [DATA_W-1:0] cfg_token,
   input  logic [LEN_W-1:0]  cfg_pkt_len,
   input  logic [CNT_W-1:0]  cfg_lock_cnt,
   input  logic [CNT_W-1:0]  cfg_drop_cnt,
   output logic              out_valid,
   output logic              out_sop,
   output logic [DATA_W-1:0] out_data,
   output logic [1:0]        sync_state,
   output logic              locked
);

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("ts_sync_lock: DATA_W must be at least 1");
      end
      if (LEN_W < 2) begin : g_bad_len
         $error("ts_sync_lock: LEN_W must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("ts_sync_lock: CNT_W must be at least 1");
      end
   endgenerate

   logic     hold_clr, acc, is_tok, at_mark;
   logic     fwd, fwd_sop, pos_clr;
   sync_st_e st_q;

   assign hold_clr = rst || !en;
   assign acc      = in_valid;
   assign is_tok   = (in_data == cfg_token);

   ts_sync_pos #(
      .LEN_W   (LEN_W),
      .DOWN_CNT(DOWN_CNT)
   ) u_pos (
      .clk    (clk),
      .clr    (pos_clr),
      .adv    (acc),
      .pkt_len(cfg_pkt_len),
      .at_mark(at_mark)
   );

   ts_sync_fsm #(
      .CNT_W(CNT_W)
   ) u_fsm (
      .clk     (clk),
      .hold_clr(hold_clr),
      .acc     (acc),
      .is_tok  (is_tok),
      .at_mark (at_mark),
      .lock_cnt(cfg_lock_cnt),
      .drop_cnt(cfg_drop_cnt),
      .state_q (st_q),
      .fwd     (fwd),
      .fwd_sop (fwd_sop),
      .pos_clr (pos_clr)
   );

   ts_sync_out #(
      .DATA_W(DATA_W)
   ) u_out (
      .clk      (clk),
      .hold_clr (hold_clr),
      .fwd      (fwd),
      .fwd_sop  (fwd_sop),
      .byte_in  (in_data),
      .out_valid(out_valid),
      .out_sop  (out_sop),
      .out_data (out_data)
   );

   assign sync_state = st_q;
   assign locked     = st_forwards(st_q);

endmodule

// File: rtl/ts_sync_lock_chk.sv
module ts_sync_lock_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              en,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_data,
   input logic [1:0]        sync_state,
   input logic              out_valid,
   input logic              out_sop,
   input logic [DATA_W-1:0] out_data
);

   // R1
   disable_to_hunt_chk: assert property (@(posedge clk) disable iff (rst)
      !en |=> (sync_state == 2'd0 && !out_valid));

   // R8
   idle_no_out_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R7
   fwd_byte_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && en) |=> (!out_valid || out_data == $past(in_data)));

   // R7
   sop_in_lock_chk: assert property (@(posedge clk) disable iff (rst)
      out_sop |-> (out_valid && sync_state[1]));

   // R2
   hunt_not_lost_chk: assert property (@(posedge clk) disable iff (rst)
      (sync_state == 2'd0) |=> (sync_state != 2'd3));

   // R4
   verify_not_lost_chk: assert property (@(posedge clk) disable iff (rst)
      (sync_state == 2'd1) |=> (sync_state != 2'd3));

   // R5
   lock_not_verify_chk: assert property (@(posedge clk) disable iff (rst)
      (sync_state == 2'd2) |=> (sync_state != 2'd1));

endmodule

bind ts_sync_lock ts_sync_lock_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .en        (en),
   .in_valid  (in_valid),
   .in_data   (in_data),
   .sync_state(sync_state),
   .out_valid (out_valid),
   .out_sop   (out_sop),
   .out_data  (out_data)
);

// File: tb/ts_sync_lock_bench.sv
module ts_sync_lock_bench;
   timeunit 1ns;
   timeprecision 1ps;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en = 1'b1;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic [7:0] cfg_token = 8'h47;
   logic [7:0] cfg_pkt_len = 8'd188;
   logic [3:0] cfg_lock_cnt = 4'd9;
   logic [3:0] cfg_drop_cnt = 4'd9;
   logic       out_valid, out_sop, locked;
   logic [7:0] out_data;
   logic [1:0] sync_state;

   int checks = 0;
   int errors = 0;
   bit cmp_on = 1'b0;
   string tag = "R1";

   always #2.5 clk = ~clk;

   ts_sync_lock u_ts_sync_lock (
      .clk(clk), .rst(rst), .en(en), .in_valid(in_valid), .in_data(in_data),
      .cfg_token(cfg_token), .cfg_pkt_len(cfg_pkt_len),
      .cfg_lock_cnt(cfg_lock_cnt), .cfg_drop_cnt(cfg_drop_cnt),
      .out_valid(out_valid), .out_sop(out_sop), .out_data(out_data),
      .sync_state(sync_state), .locked(locked)
   );

   // Behavioural reference model
   int ms = 0, mp = 0, mm = 0, mx = 0, ns = 0, len_i = 0, ll = 1, dl = 1;
   bit mov = 0, msop = 0, tok = 0, mark = 0;
   logic [7:0] mod = 8'h00;

   always @(posedge clk) begin
      if (rst || !en) begin
         ms = 0; mp = 0; mm = 0; mx = 0; mov = 0; msop = 0; mod = 8'h00;
      end else if (!in_valid) begin
         mov = 0; msop = 0;
      end else begin
         len_i = int'(cfg_pkt_len);
         ll = (cfg_lock_cnt == 0) ? 1 : int'(cfg_lock_cnt);
         dl = (cfg_drop_cnt == 0) ? 1 : int'(cfg_drop_cnt);
         tok = (in_data == cfg_token);
         mark = (mp == 0);
         ns = ms;
         if (ms == 0) begin
            if (tok) begin
               mx = 0;
               if (ll <= 1) begin ns = 2; mm = 0; end
               else begin ns = 1; mm = 1; end
            end
         end else if (mark) begin
            if (ms == 1) begin
               if (!tok) begin ns = 0; mm = 0; end
               else begin
                  mm = mm + 1;
                  if (mm >= ll) begin ns = 2; mm = 0; end
               end
            end else if (tok) begin
               ns = 2; mx = 0;
            end else begin
               mx = mx + 1;
               if (mx >= dl) begin ns = 0; mx = 0; end
               else ns = 3;
            end
         end
         mov = (ns >= 2);
         msop = mov && mark;
         if (mov) mod = in_data;
         if (ns == 0) mp = 0;
         else if (len_i <= 1) mp = 0;
         else mp = (mp + 1) % len_i;
         ms = ns;
      end
   end

   task automatic chk(input string t, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on) begin
         chk(tag, "sync_state", int'(sync_state), ms);
         chk("R7", "out_valid", int'(out_valid), int'(mov));
         chk("R7", "out_sop", int'(out_sop), int'(msop));
         chk("R5", "locked", int'(locked), int'(ms >= 2));
         if (mov) chk("R7", "out_data", int'(out_data), int'(mod));
      end
   end

   function automatic logic [7:0] noise();
      logic [7:0] v;
      v = 8'($urandom);
      if (v == cfg_token) v = v ^ 8'h01;
      return v;
   endfunction

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      in_data = b;
   endtask

   task automatic settle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic send_pkt(input bit good, input bit gaps);
      send_byte(good ? cfg_token : ~cfg_token);
      for (int i = 1; i < int'(cfg_pkt_len); i++) begin
         if (gaps && ($urandom % 3 == 0)) begin
            @(negedge clk);
            in_valid = 1'b0;
         end
         send_byte(noise());
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      cmp_on = 1'b1;
      chk("R1", "reset state", int'(sync_state), 0);
      chk("R1", "reset out_valid", int'(out_valid), 0);
      rst = 1'b0;

      tag = "R2";
      for (int i = 0; i < 50; i++) send_byte(noise());
      settle();
      chk("R2", "noise keeps hunt", int'(sync_state), 0);
      send_byte(cfg_token);
      for (int i = 0; i < 10; i++) send_byte(noise());
      settle();
      chk("R2", "token starts verify", int'(sync_state), 1);

      tag = "R4";
      for (int i = 0; i < 200; i++) send_byte(noise());
      settle();
      chk("R4", "miss in verify", int'(sync_state), 0);

      tag = "R3";
      for (int i = 0; i < 8; i++) send_pkt(1'b1, 1'b0);
      settle();
      chk("R3", "eight tokens still verify", int'(sync_state), 1);
      send_pkt(1'b1, 1'b0);
      settle();
      chk("R3", "ninth token locks", int'(sync_state), 2);
      send_byte(cfg_token);
      settle();
      chk("R7", "sop on token", int'(out_sop), 1);
      chk("R7", "token forwarded", int'(out_data), int'(cfg_token));
      for (int i = 1; i < 188; i++) send_byte(noise());

      tag = "R5";
      send_pkt(1'b0, 1'b0);
      settle();
      chk("R5", "single miss to lost", int'(sync_state), 3);
      send_pkt(1'b1, 1'b0);
      settle();
      chk("R5", "token relocks", int'(sync_state), 2);

      tag = "R6";
      for (int i = 0; i < 8; i++) send_pkt(1'b0, 1'b0);
      settle();
      chk("R6", "eight misses hold lost", int'(sync_state), 3);
      send_byte(~cfg_token);
      settle();
      chk("R6", "ninth miss to hunt", int'(sync_state), 0);
      chk("R6", "dropping byte not forwarded", int'(out_valid), 0);

      tag = "R8";
      for (int i = 0; i < 10; i++) send_pkt(1'b1, 1'b1);
      settle();
      chk("R8", "lock with gaps", int'(sync_state), 2);

      tag = "R9";
      rst = 1'b1;
      cfg_token = 8'hB8; cfg_pkt_len = 8'd16; cfg_lock_cnt = 4'd3; cfg_drop_cnt = 4'd2;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < 3; i++) send_pkt(1'b1, 1'b0);
      settle();
      chk("R9", "short packets lock", int'(sync_state), 2);
      tag = "R6";
      send_pkt(1'b0, 1'b0);
      send_byte(~cfg_token);
      settle();
      chk("R6", "drop two to hunt", int'(sync_state), 0);

      tag = "R1";
      for (int i = 0; i < 3; i++) send_pkt(1'b1, 1'b0);
      send_byte(noise());
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      chk("R1", "disable to hunt", int'(sync_state), 0);
      chk("R1", "disable stops output", int'(out_valid), 0);
      en = 1'b1;
      for (int i = 0; i < 3; i++) send_pkt(1'b1, 1'b0);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk("R1", "reset to hunt", int'(sync_state), 0);
      rst = 1'b0;

      tag = "R3";
      cfg_lock_cnt = 4'd1; cfg_drop_cnt = 4'd0;
      send_byte(cfg_token);
      settle();
      chk("R3", "lock count one", int'(sync_state), 2);
      chk("R7", "first token sop", int'(out_sop), 1);
      for (int i = 1; i < 16; i++) send_byte(noise());
      tag = "R6";
      send_byte(~cfg_token);
      settle();
      chk("R6", "drop count zero acts as one", int'(sync_state), 0);
      repeat (3) @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule